// File: doc/BRIEF.md
# Single-Wire Serial Bus Master

This block is the host end of a one-wire serial memory bus whose devices also draw their power from the data line. Every symbol sits inside a frame of fixed length. The master opens each frame by pulling the line low, and the symbol is set by how long the line stays low. The block produces reset/discovery sequences, start and stop symbols, and whole bytes. A byte is eight data frames followed by an acknowledge frame, all sent back to back with no gap. The line is open-drain: `line_oe` high means pull the line low, and `line_in` is the level read back from the wire.

Commands arrive on a valid/ready channel. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from acceptance until completion, so a held command simply waits. The sender must keep the command fields stable while `cmd_valid` is high. Completion is a one-cycle `done` pulse and cannot be back-pressured. The results (`rx_data`, `ack_rx`, `present`) stay on their outputs until a later command of the same kind replaces them. `hs_mode` chooses between two sets of cycle-count timing parameters and is sampled when a command is accepted.

Top module: `swire_host`

## Requirements
- R1: After reset, `line_oe` is 0, `cmd_ready` is 1, and `done`, `present`, `ack_rx` and `rx_data` are all 0.
- R2: A command is accepted on an edge with `cmd_valid` and `cmd_ready` both high. The line is pulled low in the very next cycle. `cmd_ready` stays 0 until the cycle in which the one-cycle `done` pulse appears, and a command held during that time is accepted in the `done` cycle.
- R3: The low time inside a frame sets the symbol: data 0, data 1, start, stop and read slot each use their own low length, taken from the timing set of the current mode.
- R4: Every frame except the reset pulse lasts exactly one bit period. The nine frames of a byte follow one another with no idle cycle. `done` rises in the cycle after the last frame's final cycle.
- R5: Write byte (`cmd_op`=3) sends `cmd_data` most significant bit first, then a read slot. `ack_rx` becomes 1 if the line was low at the sample point of that slot and 0 if it was high.
- R6: Read byte (`cmd_op`=4) issues eight read slots. A sample taken low reads as 0 and a sample taken high reads as 1, and the first slot gives bit 7 of `rx_data`. The ninth frame is sent as a data 0 when `cmd_nack`=0 and as a data 1 when `cmd_nack`=1.
- R7: Reset (`cmd_op`=0) holds the line low for the reset length, then releases it for the recovery length, then issues one read slot. `present` becomes 1 if that slot samples low and 0 if it samples high.
- R8: `hs_mode`=0 selects the standard timing set and 1 selects the fast set. The value sampled at acceptance governs the whole command, even if `hs_mode` changes while the command runs.
- R9: `cmd_op` 1 sends a single start frame and 2 sends a single stop frame. Codes 5 to 7 complete with `done` in the cycle after acceptance, do not touch the line, and leave all result outputs unchanged.
- R10: `rx_data`, `ack_rx` and `present` change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_mode | input | 1 | Timing set select: 0 standard, 1 fast |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, can take a command |
| cmd_op | input | 3 | 0 reset, 1 start, 2 stop, 3 write, 4 read |
| cmd_data | input | 8 | Byte to write |
| cmd_nack | input | 1 | On read: 1 answers NACK, 0 answers ACK |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Last byte read |
| ack_rx | output | 1 | 1 when the last write was acknowledged |
| present | output | 1 | 1 when the last discovery saw a device |
| line_oe | output | 1 | 1 pulls the bus line low |
| line_in | input | 1 | Sampled bus line level |

## Verification
The bench records the low width and start cycle of every frame, so it catches a controller that mixes up the data-0 and data-1 lengths, sends bits least significant first, or leaves an idle cycle between frames of a byte. An all-zero read and an all-ones write exercise the extremes of the shift path. A NACK read catches a design that answers with the wrong symbol. A mode change in the middle of a command shows whether the timing set is latched at acceptance. Back-to-back commands check that the second one is taken exactly in the `done` cycle. A reserved opcode must not pull the line and must not disturb the stored results.

// File: rtl/swire_pkg.sv
package swire_pkg;

  // command codes seen on cmd_op
  localparam logic [2:0] OP_RESET = 3'd0;
  localparam logic [2:0] OP_START = 3'd1;
  localparam logic [2:0] OP_STOP  = 3'd2;
  localparam logic [2:0] OP_WRITE = 3'd3;
  localparam logic [2:0] OP_READ  = 3'd4;

  // symbol kinds the frame engine can emit
  typedef enum logic [2:0] {
    FK_ZERO,
    FK_ONE,
    FK_START,
    FK_STOP,
    FK_READ,
    FK_RESET
  } frame_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SINGLE,
    ST_RST,
    ST_DISC,
    ST_WBYTE,
    ST_RBYTE
  } state_e;

endpackage

// File: rtl/swire_timing.sv
module swire_timing
  import swire_pkg::*;
#(
  parameter int STD_BIT   = 2000,
  parameter int STD_LOW0  = 600,
  parameter int STD_LOW1  = 100,
  parameter int STD_START = 1200,
  parameter int STD_STOP  = 300,
  parameter int STD_RD    = 50,
  parameter int STD_SMP   = 150,
  parameter int STD_RST   = 24000,
  parameter int STD_RCV   = 1000,
  parameter int HS_BIT    = 500,
  parameter int HS_LOW0   = 300,
  parameter int HS_LOW1   = 50,
  parameter int HS_START  = 400,
  parameter int HS_STOP   = 150,
  parameter int HS_RD     = 40,
  parameter int HS_SMP    = 100,
  parameter int HS_RST    = 2500,
  parameter int HS_RCV    = 400,
  parameter int CW        = 16
) (
  input  logic          hs,
  input  frame_e        kind,
  output logic [CW-1:0] low_cyc,
  output logic [CW-1:0] len_cyc,
  output logic [CW-1:0] smp_cyc
);

  function automatic logic [CW-1:0] pick(logic m, int s, int h);
    return m ? CW'(h) : CW'(s);
  endfunction

  always_comb begin
    len_cyc = pick(hs, STD_BIT, HS_BIT);
    smp_cyc = pick(hs, STD_SMP, HS_SMP);
    case (kind)
      FK_ZERO:  low_cyc = pick(hs, STD_LOW0, HS_LOW0);
      FK_ONE:   low_cyc = pick(hs, STD_LOW1, HS_LOW1);
      FK_START: low_cyc = pick(hs, STD_START, HS_START);
      FK_STOP:  low_cyc = pick(hs, STD_STOP, HS_STOP);
      FK_READ:  low_cyc = pick(hs, STD_RD, HS_RD);
      FK_RESET: begin
        low_cyc = pick(hs, STD_RST, HS_RST);
        len_cyc = pick(hs, STD_RST + STD_RCV, HS_RST + HS_RCV);
      end
      default:  low_cyc = pick(hs, STD_LOW1, HS_LOW1);
    endcase
  end

endmodule

// File: rtl/swire_frame.sv
module swire_frame #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] low_cyc,
  input  logic [CW-1:0] len_cyc,
  input  logic [CW-1:0] smp_cyc,
  input  logic          smp_en,
  input  logic          line_in,
  output logic          line_oe,
  output logic          fdone,
  output logic          smp_bit
);

  logic          busy;
  logic [CW-1:0] cnt, low_q, len_q, smp_q;
  logic          en_q;

  // last cycle of the running frame; a new start here chains frames
  assign fdone = busy && (cnt == len_q - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      low_q   <= '0;
      len_q   <= '0;
      smp_q   <= '0;
      en_q    <= 1'b0;
      line_oe <= 1'b0;
      smp_bit <= 1'b1;
    end else begin
      if (start && (!busy || fdone)) begin
        busy    <= 1'b1;
        cnt     <= '0;
        low_q   <= low_cyc;
        len_q   <= len_cyc;
        smp_q   <= smp_cyc;
        en_q    <= smp_en;
        line_oe <= (low_cyc != '0);
      end else if (busy) begin
        if (fdone) begin
          busy    <= 1'b0;
          line_oe <= 1'b0;
        end else begin
          cnt     <= cnt + CW'(1);
          line_oe <= (cnt + CW'(1)) < low_q;
        end
      end
      if (busy && en_q && (cnt == smp_q)) smp_bit <= line_in;
    end
  end

endmodule

// File: rtl/swire_ctrl.sv
module swire_ctrl
  import swire_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_mode,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_nack,
  output logic       fr_start,
  output frame_e     fr_kind,
  output logic       fr_smp_en,
  output logic       fr_hs,
  input  logic       fr_done,
  input  logic       fr_bit,
  output logic       done,
  output logic [7:0] rx_data,
  output logic       ack_rx,
  output logic       present
);

  state_e     state;
  logic [3:0] bidx;
  logic [7:0] sh;
  logic       nack_q, hs_q;

  assign cmd_ready = (state == ST_IDLE);
  assign fr_hs     = (state == ST_IDLE) ? hs_mode : hs_q;

  // next frame to launch
  always_comb begin
    fr_start  = 1'b0;
    fr_kind   = FK_ZERO;
    fr_smp_en = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cmd_valid) begin
          case (cmd_op)
            OP_RESET: begin fr_start = 1'b1; fr_kind = FK_RESET; end
            OP_START: begin fr_start = 1'b1; fr_kind = FK_START; end
            OP_STOP:  begin fr_start = 1'b1; fr_kind = FK_STOP;  end
            OP_WRITE: begin
              fr_start = 1'b1;
              fr_kind  = cmd_data[7] ? FK_ONE : FK_ZERO;
            end
            OP_READ: begin
              fr_start  = 1'b1;
              fr_kind   = FK_READ;
              fr_smp_en = 1'b1;
            end
            default: fr_start = 1'b0;
          endcase
        end
      end
      ST_RST: begin
        if (fr_done) begin
          fr_start  = 1'b1;
          fr_kind   = FK_READ;
          fr_smp_en = 1'b1;
        end
      end
      ST_WBYTE: begin
        if (fr_done && bidx < 4'd8) begin
          fr_start = 1'b1;
          if (bidx == 4'd7) begin
            fr_kind   = FK_READ;
            fr_smp_en = 1'b1;
          end else begin
            fr_kind = sh[7] ? FK_ONE : FK_ZERO;
          end
        end
      end
      ST_RBYTE: begin
        if (fr_done && bidx < 4'd8) begin
          fr_start = 1'b1;
          if (bidx == 4'd7) begin
            fr_kind = nack_q ? FK_ONE : FK_ZERO;
          end else begin
            fr_kind   = FK_READ;
            fr_smp_en = 1'b1;
          end
        end
      end
      default: fr_start = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bidx    <= '0;
      sh      <= '0;
      nack_q  <= 1'b0;
      hs_q    <= 1'b0;
      done    <= 1'b0;
      rx_data <= '0;
      ack_rx  <= 1'b0;
      present <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            hs_q   <= hs_mode;
            nack_q <= cmd_nack;
            bidx   <= '0;
            sh     <= {cmd_data[6:0], 1'b0};
            case (cmd_op)
              OP_RESET: state <= ST_RST;
              OP_START: state <= ST_SINGLE;
              OP_STOP:  state <= ST_SINGLE;
              OP_WRITE: state <= ST_WBYTE;
              OP_READ:  state <= ST_RBYTE;
              default:  done  <= 1'b1;
            endcase
          end
        end
        ST_SINGLE: begin
          if (fr_done) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_RST: begin
          if (fr_done) state <= ST_DISC;
        end
        ST_DISC: begin
          if (fr_done) begin
            present <= !fr_bit;
            done    <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_WBYTE: begin
          if (fr_done) begin
            if (bidx == 4'd8) begin
              ack_rx <= !fr_bit;
              done   <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              bidx <= bidx + 4'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end
        ST_RBYTE: begin
          if (fr_done) begin
            if (bidx == 4'd8) begin
              rx_data <= sh;
              done    <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              bidx <= bidx + 4'd1;
              if (bidx < 4'd8) sh <= {sh[6:0], fr_bit};
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/swire_host.sv
module swire_host
  import swire_pkg::*;
#(
  parameter int STD_BIT   = 2000,
  parameter int STD_LOW0  = 600,
  parameter int STD_LOW1  = 100,
  parameter int STD_START = 1200,
  parameter int STD_STOP  = 300,
  parameter int STD_RD    = 50,
  parameter int STD_SMP   = 150,
  parameter int STD_RST   = 24000,
  parameter int STD_RCV   = 1000,
  parameter int HS_BIT    = 500,
  parameter int HS_LOW0   = 300,
  parameter int HS_LOW1   = 50,
  parameter int HS_START  = 400,
  parameter int HS_STOP   = 150,
  parameter int HS_RD     = 40,
  parameter int HS_SMP    = 100,
  parameter int HS_RST    = 2500,
  parameter int HS_RCV    = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_mode,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_nack,
  output logic       done,
  output logic [7:0] rx_data,
  output logic       ack_rx,
  output logic       present,
  output logic       line_oe,
  input  logic       line_in
);

  localparam int STD_RLEN = STD_RST + STD_RCV;
  localparam int HS_RLEN  = HS_RST + HS_RCV;
  localparam int STD_MAX  = (STD_RLEN > STD_BIT) ? STD_RLEN : STD_BIT;
  localparam int HS_MAX   = (HS_RLEN > HS_BIT) ? HS_RLEN : HS_BIT;
  localparam int MAXLEN   = (STD_MAX > HS_MAX) ? STD_MAX : HS_MAX;
  localparam int CW       = $clog2(MAXLEN + 1);

  logic          fr_start, fr_smp_en, fr_hs, fr_done, fr_bit;
  frame_e        fr_kind;
  logic [CW-1:0] low_cyc, len_cyc, smp_cyc;

  swire_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_mode   (hs_mode),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .cmd_nack  (cmd_nack),
    .fr_start  (fr_start),
    .fr_kind   (fr_kind),
    .fr_smp_en (fr_smp_en),
    .fr_hs     (fr_hs),
    .fr_done   (fr_done),
    .fr_bit    (fr_bit),
    .done      (done),
    .rx_data   (rx_data),
    .ack_rx    (ack_rx),
    .present   (present)
  );

  swire_timing #(
    .STD_BIT (STD_BIT), .STD_LOW0 (STD_LOW0), .STD_LOW1 (STD_LOW1),
    .STD_START (STD_START), .STD_STOP (STD_STOP), .STD_RD (STD_RD),
    .STD_SMP (STD_SMP), .STD_RST (STD_RST), .STD_RCV (STD_RCV),
    .HS_BIT (HS_BIT), .HS_LOW0 (HS_LOW0), .HS_LOW1 (HS_LOW1),
    .HS_START (HS_START), .HS_STOP (HS_STOP), .HS_RD (HS_RD),
    .HS_SMP (HS_SMP), .HS_RST (HS_RST), .HS_RCV (HS_RCV),
    .CW (CW)
  ) u_timing (
    .hs      (fr_hs),
    .kind    (fr_kind),
    .low_cyc (low_cyc),
    .len_cyc (len_cyc),
    .smp_cyc (smp_cyc)
  );

  swire_frame #(.CW (CW)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (fr_start),
    .low_cyc (low_cyc),
    .len_cyc (len_cyc),
    .smp_cyc (smp_cyc),
    .smp_en  (fr_smp_en),
    .line_in (line_in),
    .line_oe (line_oe),
    .fdone   (fr_done),
    .smp_bit (fr_bit)
  );

endmodule

// File: rtl/swire_host_chk.sv
module swire_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic       done,
  input logic [7:0] rx_data,
  input logic       ack_rx,
  input logic       present,
  input logic       line_oe
);

  // idle controller leaves the line released
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !line_oe);

  // completion is a single-cycle pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // controller is free again in the completion cycle
  assert_done_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  // an accepted line command pulls low in the next cycle
  assert_accept_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op <= 3'd4) |=> line_oe);

  // reserved codes finish at once without touching the line
  assert_reserved_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op > 3'd4) |=> (done && !line_oe));

  // results move only with completion
  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rx_data));
  assert_ack_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ack_rx));
  assert_present_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(present));

endmodule

bind swire_host swire_host_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .done      (done),
  .rx_data   (rx_data),
  .ack_rx    (ack_rx),
  .present   (present),
  .line_oe   (line_oe)
);

// File: tb/swire_host_tb.sv
module swire_host_tb_top;

  localparam int S_BIT = 20, S_L0 = 9, S_L1 = 2, S_ST = 14, S_SP = 5,
                 S_RD = 1, S_SMP = 6, S_RST = 60, S_RCV = 10;
  localparam int H_BIT = 12, H_L0 = 6, H_L1 = 2, H_ST = 9, H_SP = 4,
                 H_RD = 1, H_SMP = 4, H_RST = 30, H_RCV = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_mode = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'h00;
  logic       cmd_nack = 1'b0;
  logic       cmd_ready, done, ack_rx, present, line_oe, line_in;
  logic [7:0] rx_data;
  logic       dev_pull = 1'b0;

  assign line_in = !(line_oe || dev_pull);

  always #10 clk = ~clk;

  swire_host #(
    .STD_BIT (S_BIT), .STD_LOW0 (S_L0), .STD_LOW1 (S_L1), .STD_START (S_ST),
    .STD_STOP (S_SP), .STD_RD (S_RD), .STD_SMP (S_SMP), .STD_RST (S_RST),
    .STD_RCV (S_RCV),
    .HS_BIT (H_BIT), .HS_LOW0 (H_L0), .HS_LOW1 (H_L1), .HS_START (H_ST),
    .HS_STOP (H_SP), .HS_RD (H_RD), .HS_SMP (H_SMP), .HS_RST (H_RST),
    .HS_RCV (H_RCV)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .hs_mode (hs_mode),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_op (cmd_op),
    .cmd_data (cmd_data), .cmd_nack (cmd_nack), .done (done),
    .rx_data (rx_data), .ack_rx (ack_rx), .present (present),
    .line_oe (line_oe), .line_in (line_in)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // line monitor and device model, acting a quarter period after each edge
  int       cyc = 0;
  int       nfr = 0;
  int       rise [16];
  int       wid  [16];
  int       wcnt = 0;
  logic     oe_d = 1'b0;
  logic [8:0] dev_q = 9'h1FF;
  logic     cur_hs = 1'b0;
  int       pleft = 0;
  int       done_cyc = -1;

  initial begin
    forever begin
      @(posedge clk);
      #5;
      cyc++;
      if (done) done_cyc = cyc;
      if (pleft > 0) begin
        pleft--;
        if (pleft == 0) dev_pull = 1'b0;
      end
      if (line_oe && !oe_d) begin
        if (nfr < 16) rise[nfr] = cyc;
        wcnt = 0;
        if (!dev_q[8]) begin
          dev_pull = 1'b1;
          pleft = (cur_hs ? H_SMP : S_SMP) + 2;
        end
        dev_q = {dev_q[7:0], 1'b1};
      end
      if (line_oe) wcnt++;
      if (!line_oe && oe_d) begin
        if (nfr < 16) wid[nfr] = wcnt;
        nfr++;
      end
      oe_d = line_oe;
    end
  end

  // expected frame shapes, from the requirements
  function automatic int n_frames(input logic [2:0] op);
    case (op)
      3'd0: return 2;
      3'd1, 3'd2: return 1;
      3'd3, 3'd4: return 9;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_low(input logic m, input logic [2:0] op,
                                 input logic [7:0] d, input logic nk, input int k);
    int l0 = m ? H_L0 : S_L0;
    int l1 = m ? H_L1 : S_L1;
    int rd = m ? H_RD : S_RD;
    case (op)
      3'd0: return (k == 0) ? (m ? H_RST : S_RST) : rd;
      3'd1: return m ? H_ST : S_ST;
      3'd2: return m ? H_SP : S_SP;
      3'd3: return (k == 8) ? rd : (d[7-k] ? l1 : l0);
      default: return (k == 8) ? (nk ? l1 : l0) : rd;
    endcase
  endfunction

  function automatic int exp_len(input logic m, input logic [2:0] op, input int k);
    if (op == 3'd0 && k == 0) return m ? (H_RST + H_RCV) : (S_RST + S_RCV);
    return m ? H_BIT : S_BIT;
  endfunction

  task automatic issue(input logic m, input logic [2:0] op, input logic [7:0] d,
                       input logic nk, output int acc);
    @(negedge clk);
    hs_mode = m; cmd_op = op; cmd_data = d; cmd_nack = nk; cmd_valid = 1'b1;
    cur_hs = m;
    while (!cmd_ready) @(negedge clk);
    acc = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input string req, output int dc);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk(1'b0, req, "watchdog waiting for done", 0, 1);
    dc = cyc;
    @(negedge clk);
    chk(done == 1'b0, "R2", "done lasts one cycle", done, 0);
  endtask

  // walk recorded frames against the expected shape
  task automatic check_frames(input logic m, input logic [2:0] op,
                              input logic [7:0] d, input logic nk,
                              input int acc, input int dc);
    int nf = n_frames(op);
    int total = 0;
    bit wok = 1'b1;
    bit gok = 1'b1;
    chk(nfr == nf, "R4", "frame count", nfr, nf);
    if (nf > 0) chk(rise[0] == acc + 1, "R2", "first low cycle", rise[0], acc + 1);
    for (int k = 0; k < nf && k < nfr; k++) begin
      if (wid[k] != exp_low(m, op, d, nk, k)) begin
        wok = 1'b0;
        $display("  frame %0d width %0d expected %0d", k, wid[k], exp_low(m, op, d, nk, k));
      end
      if (k + 1 < nfr && rise[k+1] - rise[k] != exp_len(m, op, k)) gok = 1'b0;
      total += exp_len(m, op, k);
    end
    chk(wok, "R3", "symbol low widths", int'(wok), 1);
    chk(gok, "R4", "frame spacing", int'(gok), 1);
    chk(dc == acc + 1 + total, "R4", "done cycle", dc - acc, 1 + total);
  endtask

  typedef struct packed {
    logic       hs;
    logic [2:0] op;
    logic [7:0] data;
    logic       nack;
    logic [8:0] dev;
    logic [7:0] erx;
    logic       eack;
    logic       epres;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd0, 8'h00, 1'b0, 9'h17F, 8'h00, 1'b0, 1'b1},
    '{1'b0, 3'd1, 8'h00, 1'b0, 9'h1FF, 8'h00, 1'b0, 1'b0},
    '{1'b0, 3'd3, 8'hA5, 1'b0, 9'h1FE, 8'h00, 1'b1, 1'b0},
    '{1'b0, 3'd3, 8'h3C, 1'b0, 9'h1FF, 8'h00, 1'b0, 1'b0},
    '{1'b0, 3'd4, 8'h00, 1'b0, 9'h12D, 8'h96, 1'b0, 1'b0},
    '{1'b0, 3'd4, 8'h00, 1'b1, 9'h001, 8'h00, 1'b0, 1'b0},
    '{1'b1, 3'd2, 8'h00, 1'b0, 9'h1FF, 8'h00, 1'b0, 1'b0},
    '{1'b1, 3'd3, 8'hFF, 1'b0, 9'h1FE, 8'h00, 1'b1, 1'b0},
    '{1'b1, 3'd4, 8'h00, 1'b0, 9'h1FF, 8'hFF, 1'b0, 1'b0},
    '{1'b1, 3'd0, 8'h00, 1'b0, 9'h1FF, 8'h00, 1'b0, 1'b0},
    '{1'b1, 3'd3, 8'h00, 1'b0, 9'h1FE, 8'h00, 1'b1, 1'b0}
  };

  initial begin
    int acc, dc, acc2;
    logic [7:0] rx_keep;
    logic ack_keep, pres_keep;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(line_oe == 1'b0, "R1", "line_oe after reset", line_oe, 0);
    chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
    chk(done == 1'b0 && present == 1'b0 && ack_rx == 1'b0 && rx_data == 8'h00,
        "R1", "results after reset", {done, present, ack_rx, rx_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_oe == 1'b0 && cmd_ready == 1'b1, "R1", "idle after release",
        {line_oe, cmd_ready}, 1);

    // table of vectors covering R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      nfr = 0;
      dev_q = v.dev;
      issue(v.hs, v.op, v.data, v.nack, acc);
      wait_done("R4", dc);
      check_frames(v.hs, v.op, v.data, v.nack, acc, dc);
      case (v.op)
        3'd0: chk(present == v.epres, "R7", "present flag", present, v.epres);
        3'd3: chk(ack_rx == v.eack, "R5", "ack_rx after write", ack_rx, v.eack);
        3'd4: chk(rx_data == v.erx, "R6", "rx_data after read", rx_data, v.erx);
        default: chk(line_oe == 1'b0, "R9", "line released after single frame", line_oe, 0);
      endcase
    end

    // R9: reserved code does nothing on the line and keeps results
    rx_keep = rx_data; ack_keep = ack_rx; pres_keep = present;
    nfr = 0;
    issue(1'b0, 3'd6, 8'h5A, 1'b0, acc);
    wait_done("R9", dc);
    chk(dc == acc + 1, "R9", "reserved code done cycle", dc - acc, 1);
    repeat (3) @(negedge clk);
    chk(nfr == 0, "R9", "reserved code frames", nfr, 0);
    chk(rx_data == rx_keep && ack_rx == ack_keep && present == pres_keep,
        "R9", "results kept", {rx_data, ack_rx, present}, {rx_keep, ack_keep, pres_keep});

    // R8: mode change during a command has no effect on its timing
    nfr = 0;
    dev_q = 9'h1FE;
    issue(1'b0, 3'd3, 8'h69, 1'b0, acc);
    repeat (30) @(negedge clk);
    hs_mode = 1'b1;
    wait_done("R8", dc);
    check_frames(1'b0, 3'd3, 8'h69, 1'b0, acc, dc);
    chk(ack_rx == 1'b1, "R8", "ack with mode flipped", ack_rx, 1);

    // R2: a held command waits and is taken in the done cycle
    nfr = 0;
    dev_q = 9'h1FF;
    issue(1'b1, 3'd1, 8'h00, 1'b0, acc);
    repeat (2) @(negedge clk);
    chk(cmd_ready == 1'b0, "R2", "ready low while busy", cmd_ready, 0);
    issue(1'b1, 3'd2, 8'h00, 1'b0, acc2);
    chk(acc2 == done_cyc, "R2", "held command taken in done cycle", acc2, done_cyc);
    wait_done("R2", dc);
    chk(nfr == 2, "R2", "frames of two commands", nfr, 2);
    chk(wid[0] == H_ST && wid[1] == H_SP, "R3", "start then stop widths",
        wid[0] * 100 + wid[1], H_ST * 100 + H_SP);
    chk(rise[1] == acc2 + 1, "R2", "second command first low", rise[1], acc2 + 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule